// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of hardware semaphores that two independent bus sides, a host side and a processor side, use to share a resource. Each side has its own plain register port: an address, a write strobe with a one-bit write value, a read strobe and read data. A side claims a semaphore by writing 0 to it and gives it up by writing 1. A read tells the side whether it holds that semaphore at that moment.

A claim that is refused because the other side holds the semaphore is not lost. It stays latched as a waiting request, and the semaphore passes straight to the waiting side in the same clock edge that the owner's release takes effect. A side can withdraw its waiting request by writing 1. Ownership is reported as an all-zero or all-one 16-bit flag in the low half of the read word. The upper half is always zero.

On the host side each semaphore takes a 32-bit-aligned byte offset in a 32-byte window, so the semaphore index is address bits [4:2]. On the processor side the address is the semaphore index.

Top module: `sem_bank`

## Requirements
- R1: After reset, and after any later reset, every semaphore is free with no waiting request, every read from either side returns 0x0000FFFF, and both read data outputs hold 0x0000FFFF until the first read.
- R2: A write with value 0 to a free semaphore makes the writing side its owner, and a later read of it from that side returns 0x0000.
- R3: While one side owns a semaphore, reads of it from the other side return 0xFFFF, and a write of 0 from the other side does not take ownership.
- R4: A write with value 1 from the owner, with no request waiting, frees the semaphore, so reads from both sides return 0xFFFF.
- R5: A refused request stays waiting, and when the owner writes 1 the semaphore passes to the waiting side at that same edge; the same holds when the request arrives in the very cycle of the release.
- R6: A write of 1 from a side that only has a waiting request withdraws the request and leaves the owner in place; a later release by the owner then frees the semaphore.
- R7: When both sides write 0 to the same free semaphore in the same cycle, the processor side becomes the owner and the host request is left waiting.
- R8: Only bits [15:0] of a read carry the flag; bits [31:16] of both read data outputs are always zero.
- R9: The semaphores are independent: an operation on one index changes no other index. Host index is host address bits [4:2]; processor index is the processor address.
- R10: Read data is registered: it shows the state before that cycle's writes, appears one clock after the read strobe, and holds its value while no read is made.
- R11: A host access whose address bits [1:0] are not zero is ignored: a write changes no semaphore and a read leaves the host read data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 5 | Host byte offset in the 32-byte window; index in bits [4:2] |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wval | input | 1 | Host write value: 0 claims, 1 releases or withdraws |
| host_rdata | output | 32 | Host read data, flag in bits [15:0] |
| proc_addr | input | 3 | Processor semaphore index |
| proc_wr | input | 1 | Processor write strobe |
| proc_rd | input | 1 | Processor read strobe |
| proc_wval | input | 1 | Processor write value: 0 claims, 1 releases or withdraws |
| proc_rdata | output | 32 | Processor read data, flag in bits [15:0] |

## Verification
The two functions that meet in one cycle are the claims of both sides, and an owner's release with the other side's claim. The bench drives both ports at the same falling edge: two claims on a free index, where the processor must win and the host must take over once the processor releases, and a host release together with a processor claim, where the processor must end up owner. Each outcome is judged by reads from both sides afterwards.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int SEM_COUNT = 8;
    localparam int BUS_W     = 32;
    localparam int FLAG_W    = 16;

    typedef enum logic [1:0] {
        HOLD_NONE = 2'd0,
        HOLD_PROC = 2'd1,
        HOLD_HOST = 2'd2
    } holder_e;

    typedef struct packed {
        holder_e holder;
        logic    wait_proc;
        logic    wait_host;
    } sem_state_t;

    typedef struct packed {
        logic take;
        logic drop;
    } side_op_t;

    localparam sem_state_t SEM_IDLE = '{holder: HOLD_NONE, wait_proc: 1'b0, wait_host: 1'b0};

    // Flag word: zeros when the reader holds the semaphore, ones otherwise.
    function automatic logic [FLAG_W-1:0] flag_word(input logic owned);
        return owned ? {FLAG_W{1'b0}} : {FLAG_W{1'b1}};
    endfunction

    // Next state of one semaphore from the operations of both sides.
    function automatic sem_state_t sem_step(input sem_state_t cur,
                                            input side_op_t   p,
                                            input side_op_t   h);
        sem_state_t nx;
        logic       wh;
        logic       wp;
        nx = cur;
        wh = (cur.wait_host | h.take) & ~h.drop;
        wp = (cur.wait_proc | p.take) & ~p.drop;
        unique case (cur.holder)
            HOLD_NONE: begin
                nx.wait_proc = 1'b0;
                nx.wait_host = 1'b0;
                if (p.take) begin
                    nx.holder    = HOLD_PROC;
                    nx.wait_host = h.take;
                end else if (h.take) begin
                    nx.holder = HOLD_HOST;
                end
            end
            HOLD_PROC: begin
                nx.wait_proc = 1'b0;
                if (p.drop) begin
                    nx.holder    = wh ? HOLD_HOST : HOLD_NONE;
                    nx.wait_host = 1'b0;
                end else begin
                    nx.wait_host = wh;
                end
            end
            HOLD_HOST: begin
                nx.wait_host = 1'b0;
                if (h.drop) begin
                    nx.holder    = wp ? HOLD_PROC : HOLD_NONE;
                    nx.wait_proc = 1'b0;
                end else begin
                    nx.wait_proc = wp;
                end
            end
            default: nx = SEM_IDLE;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/sem_side_decode.sv
module sem_side_decode
    import sem_pkg::*;
#(
    parameter int NUM_SEM = SEM_COUNT,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    input  logic             val,
    output side_op_t         ops [NUM_SEM]
);

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_op
        logic hit;
        assign hit         = en && (idx == IDX_W'(g));
        assign ops[g].take = hit && !val;
        assign ops[g].drop = hit && val;
    end

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  side_op_t   p_op,
    input  side_op_t   h_op,
    output sem_state_t st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SEM_IDLE;
        end else begin
            st <= sem_step(st, p_op, h_op);
        end
    end

endmodule

// File: rtl/sem_side_read.sv
module sem_side_read
    import sem_pkg::*;
#(
    parameter int NUM_SEM = SEM_COUNT,
    parameter int DATA_W  = BUS_W,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] owned,
    output logic [DATA_W-1:0]  rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= DATA_W'(flag_word(1'b0));
        end else if (en) begin
            rdata <= DATA_W'(flag_word(owned[idx]));
        end
    end

endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int NUM_SEM  = SEM_COUNT,
    parameter int DATA_W   = BUS_W,
    localparam int IDX_W   = $clog2(NUM_SEM),
    localparam int HADDR_W = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic               host_wval,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic [IDX_W-1:0]   proc_addr,
    input  logic               proc_wr,
    input  logic               proc_rd,
    input  logic               proc_wval,
    output logic [DATA_W-1:0]  proc_rdata
);

    logic             host_aligned;
    logic [IDX_W-1:0] host_idx;
    side_op_t         p_ops [NUM_SEM];
    side_op_t         h_ops [NUM_SEM];
    sem_state_t       st    [NUM_SEM];

    logic [NUM_SEM-1:0] own_p_vec;
    logic [NUM_SEM-1:0] own_h_vec;
    logic [NUM_SEM-1:0] wait_p_vec;
    logic [NUM_SEM-1:0] wait_h_vec;

    assign host_aligned = (host_addr[1:0] == 2'b00);
    assign host_idx     = host_addr[HADDR_W-1:2];

    sem_side_decode #(.NUM_SEM(NUM_SEM)) u_dec_proc (
        .en  (proc_wr),
        .idx (proc_addr),
        .val (proc_wval),
        .ops (p_ops)
    );

    sem_side_decode #(.NUM_SEM(NUM_SEM)) u_dec_host (
        .en  (host_wr && host_aligned),
        .idx (host_idx),
        .val (host_wval),
        .ops (h_ops)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
        sem_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .p_op (p_ops[g]),
            .h_op (h_ops[g]),
            .st   (st[g])
        );
        assign own_p_vec[g]  = (st[g].holder == HOLD_PROC);
        assign own_h_vec[g]  = (st[g].holder == HOLD_HOST);
        assign wait_p_vec[g] = st[g].wait_proc;
        assign wait_h_vec[g] = st[g].wait_host;
    end

    sem_side_read #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_proc (
        .clk   (clk),
        .rst   (rst),
        .en    (proc_rd),
        .idx   (proc_addr),
        .owned (own_p_vec),
        .rdata (proc_rdata)
    );

    sem_side_read #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_host (
        .clk   (clk),
        .rst   (rst),
        .en    (host_rd && host_aligned),
        .idx   (host_idx),
        .owned (own_h_vec),
        .rdata (host_rdata)
    );

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk
    import sem_pkg::*;
#(
    parameter int NUM_SEM  = SEM_COUNT,
    parameter int DATA_W   = BUS_W,
    localparam int IDX_W   = $clog2(NUM_SEM),
    localparam int HADDR_W = IDX_W + 2
) (
    input logic               clk,
    input logic               rst,
    input logic [HADDR_W-1:0] host_addr,
    input logic               host_wr,
    input logic               host_rd,
    input logic               host_wval,
    input logic [DATA_W-1:0]  host_rdata,
    input logic [IDX_W-1:0]   proc_addr,
    input logic               proc_wr,
    input logic               proc_rd,
    input logic               proc_wval,
    input logic [DATA_W-1:0]  proc_rdata,
    input logic [NUM_SEM-1:0] own_p,
    input logic [NUM_SEM-1:0] own_h,
    input logic [NUM_SEM-1:0] wait_p,
    input logic [NUM_SEM-1:0] wait_h
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: the first edge after reset leaves both outputs at the idle flag
    always_ff @(posedge clk) begin
        if (rst_q && !rst) begin
            a_r1_idle_flag: assert (host_rdata == DATA_W'(16'hFFFF) && proc_rdata == DATA_W'(16'hFFFF))
                else $error("a_r1_idle_flag");
        end
    end

    a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
        host_rdata[DATA_W-1:FLAG_W] == '0 && proc_rdata[DATA_W-1:FLAG_W] == '0);

    a_r10_host_hold: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));

    a_r10_proc_hold: assert property (@(posedge clk) disable iff (rst)
        !proc_rd |=> $stable(proc_rdata));

    // R3: both sides reading one index never both see ownership
    a_r3_exclusive_reads: assert property (@(posedge clk) disable iff (rst)
        (host_rd && proc_rd && host_addr[1:0] == 2'b00 && host_addr[HADDR_W-1:2] == proc_addr)
        |=> !(host_rdata[FLAG_W-1:0] == '0 && proc_rdata[FLAG_W-1:0] == '0));

    // R7: tie on a free semaphore goes to the processor side
    a_r7_tie_proc: assert property (@(posedge clk) disable iff (rst)
        (proc_wr && !proc_wval && host_wr && !host_wval && host_addr[1:0] == 2'b00 &&
         host_addr[HADDR_W-1:2] == proc_addr && !own_p[proc_addr] && !own_h[proc_addr])
        |=> own_p[$past(proc_addr)] && wait_h[$past(proc_addr)]);

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem_chk
        // R5: a waiting request only exists while the other side owns
        a_r5_host_wait_owner: assert property (@(posedge clk) disable iff (rst)
            wait_h[g] |-> own_p[g]);
        a_r5_proc_wait_owner: assert property (@(posedge clk) disable iff (rst)
            wait_p[g] |-> own_h[g]);
    end

endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wval  (host_wval),
    .host_rdata (host_rdata),
    .proc_addr  (proc_addr),
    .proc_wr    (proc_wr),
    .proc_rd    (proc_rd),
    .proc_wval  (proc_wval),
    .proc_rdata (proc_rdata),
    .own_p      (own_p_vec),
    .own_h      (own_h_vec),
    .wait_p     (wait_p_vec),
    .wait_h     (wait_h_vec)
);

// File: tb/tb_sem_bank.sv
module tb_sem_bank;

    localparam int CLK_P = 10;
    localparam int NV    = 25;

    // kinds: 0 = write 0 (claim), 1 = write 1 (release), 2 = read, 3 = idle
    // fields: [25:22] requirement, [21] 1=host 0=proc, [20:19] kind, [18:16] index, [15:0] expected flag
    localparam logic [25:0] VECS [NV] = '{
        {4'd2, 1'b0, 2'd0, 3'd0, 16'h0000},  // R2 proc claims 0
        {4'd2, 1'b0, 2'd2, 3'd0, 16'h0000},  // R2
        {4'd3, 1'b1, 2'd2, 3'd0, 16'hFFFF},  // R3 host sees busy
        {4'd5, 1'b1, 2'd0, 3'd0, 16'h0000},  // R5 host refused, waits
        {4'd3, 1'b1, 2'd2, 3'd0, 16'hFFFF},  // R3
        {4'd3, 1'b0, 2'd2, 3'd0, 16'h0000},  // R3 proc still owner
        {4'd5, 1'b0, 2'd1, 3'd0, 16'h0000},  // R5 proc releases
        {4'd5, 1'b1, 2'd2, 3'd0, 16'h0000},  // R5 host granted
        {4'd5, 1'b0, 2'd2, 3'd0, 16'hFFFF},  // R5
        {4'd6, 1'b0, 2'd0, 3'd0, 16'h0000},  // R6 proc waits
        {4'd6, 1'b0, 2'd1, 3'd0, 16'h0000},  // R6 proc withdraws
        {4'd6, 1'b1, 2'd2, 3'd0, 16'h0000},  // R6 host still owner
        {4'd6, 1'b1, 2'd1, 3'd0, 16'h0000},  // R6 host releases
        {4'd6, 1'b0, 2'd2, 3'd0, 16'hFFFF},  // R6 no grant to proc
        {4'd4, 1'b1, 2'd2, 3'd0, 16'hFFFF},  // R4 free
        {4'd9, 1'b1, 2'd0, 3'd5, 16'h0000},  // R9 host claims 5
        {4'd9, 1'b1, 2'd2, 3'd5, 16'h0000},  // R9
        {4'd9, 1'b0, 2'd2, 3'd4, 16'hFFFF},  // R9 neighbour untouched
        {4'd9, 1'b0, 2'd0, 3'd4, 16'h0000},  // R9 proc claims 4
        {4'd9, 1'b0, 2'd2, 3'd4, 16'h0000},  // R9
        {4'd9, 1'b1, 2'd2, 3'd5, 16'h0000},  // R9 5 unaffected
        {4'd4, 1'b1, 2'd1, 3'd5, 16'h0000},  // R4 host releases 5
        {4'd4, 1'b1, 2'd2, 3'd5, 16'hFFFF},  // R4
        {4'd4, 1'b0, 2'd1, 3'd4, 16'h0000},  // R4 proc releases 4
        {4'd4, 1'b0, 2'd2, 3'd4, 16'hFFFF}   // R4
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_wval = 1'b0;
    logic [31:0] host_rdata;
    logic [2:0]  proc_addr = '0;
    logic        proc_wr = 1'b0;
    logic        proc_rd = 1'b0;
    logic        proc_wval = 1'b0;
    logic [31:0] proc_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    sem_bank dut (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wval  (host_wval),
        .host_rdata (host_rdata),
        .proc_addr  (proc_addr),
        .proc_wr    (proc_wr),
        .proc_rd    (proc_rd),
        .proc_wval  (proc_wval),
        .proc_rdata (proc_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle with optional operations on both sides; results sampled at the following falling edge.
    task automatic both(input int pk, input int pi, input int hk, input int hi,
                        output logic [31:0] prd, output logic [31:0] hrd);
        @(negedge clk);
        proc_addr = 3'(pi);
        proc_wr   = (pk < 2);
        proc_wval = (pk == 1);
        proc_rd   = (pk == 2);
        host_addr = 5'(hi << 2);
        host_wr   = (hk < 2);
        host_wval = (hk == 1);
        host_rd   = (hk == 2);
        @(negedge clk);
        proc_wr = 1'b0; proc_rd = 1'b0;
        host_wr = 1'b0; host_rd = 1'b0;
        prd = proc_rdata;
        hrd = host_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_err++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] pr, hr;
        do_reset();

        // R1: idle outputs and every index free from both sides
        check("R1 host idle rdata", host_rdata, 32'h0000FFFF);
        check("R1 proc idle rdata", proc_rdata, 32'h0000FFFF);
        for (int i = 0; i < 8; i++) begin
            both(2, i, 2, i, pr, hr);
            check("R1 proc read after reset", pr, 32'h0000FFFF);
            check("R1 host read after reset", hr, 32'h0000FFFF);
        end

        // Table walk; R8: full 32-bit compare keeps upper half at zero
        for (int v = 0; v < NV; v++) begin
            logic [25:0] e;
            int kd;
            e  = VECS[v];
            kd = int'(e[20:19]);
            if (e[21]) both(3, 0, kd, int'(e[18:16]), pr, hr);
            else       both(kd, int'(e[18:16]), 3, 0, pr, hr);
            if (kd == 2) begin
                check($sformatf("R%0d vector %0d", e[25:22], v),
                      e[21] ? hr : pr, {16'h0000, e[15:0]});
            end
        end

        // R10: read data holds while no read is made, then follows the state
        both(3, 0, 2, 6, pr, hr);
        check("R10 host read of free 6", hr, 32'h0000FFFF);
        both(3, 0, 0, 6, pr, hr);
        check("R10 host rdata held after claim", hr, 32'h0000FFFF);
        both(3, 0, 2, 6, pr, hr);
        check("R10 host read after claim", hr, 32'h00000000);
        both(3, 0, 1, 6, pr, hr);

        // R11: misaligned host write ignored
        @(negedge clk);
        host_addr = 5'h09; host_wr = 1'b1; host_wval = 1'b0;
        @(negedge clk);
        host_wr = 1'b0;
        both(0, 2, 3, 0, pr, hr);
        both(2, 2, 2, 2, pr, hr);
        check("R11 proc took 2 after misaligned host write", pr, 32'h00000000);
        check("R11 host not owner of 2", hr, 32'h0000FFFF);
        // R11: misaligned host read leaves rdata unchanged
        both(3, 0, 0, 7, pr, hr);
        @(negedge clk);
        host_addr = 5'h1D; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check("R11 host rdata after misaligned read", host_rdata, 32'h0000FFFF);

        // R7: simultaneous claims on free 3, processor wins, host waits
        both(0, 3, 0, 3, pr, hr);
        both(2, 3, 2, 3, pr, hr);
        check("R7 proc wins tie", pr, 32'h00000000);
        check("R7 host loses tie", hr, 32'h0000FFFF);
        both(1, 3, 3, 0, pr, hr);
        both(2, 3, 2, 3, pr, hr);
        check("R7 waiting host granted on release", hr, 32'h00000000);
        check("R7 proc no longer owner", pr, 32'h0000FFFF);
        both(3, 0, 1, 3, pr, hr);

        // R5: release and claim in the same cycle hands over at once
        both(3, 0, 0, 1, pr, hr);
        both(0, 1, 1, 1, pr, hr);
        both(2, 1, 2, 1, pr, hr);
        check("R5 proc owns after same-cycle handover", pr, 32'h00000000);
        check("R5 host released", hr, 32'h0000FFFF);

        // R1: reset in mid-run frees everything
        do_reset();
        check("R1 host rdata after second reset", host_rdata, 32'h0000FFFF);
        both(2, 1, 2, 7, pr, hr);
        check("R1 proc 1 free after reset", pr, 32'h0000FFFF);
        check("R1 host 7 free after reset", hr, 32'h0000FFFF);
        both(3, 0, 0, 1, pr, hr);
        both(3, 0, 2, 1, pr, hr);
        check("R1 no stale request on 1", hr, 32'h00000000);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule